// File: doc/BRIEF.md
# Two-Colour Cursor Overlay Generator

This block draws a small two-colour cursor on top of a raster scan. Software writes a packed position word and up to 32 rows of cursor bitmap through a simple write port. Each row has two 32-bit words: a mask word that says which pixels are drawn, and an image word that picks the colour of each drawn pixel. During scan-out the video timing logic presents the current pixel coordinate on every clock. One cycle later the block reports whether that pixel belongs to the cursor and, if it does, whether the foreground or the background cursor colour applies.

All writes land in a shadow copy. A frame-start pulse moves the whole shadow copy (position and both planes) into the active copy used for matching, so a cursor never shows half of an old shape and half of a new one. The position is stored as two's-complement X and Y, so the cursor can hang off the left or top edge. One reserved coordinate value in both halves hides the cursor completely.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and after it is released, cursor_on and cursor_fg are 0. Both bitmap planes are cleared to zero, and the position in both the shadow and the active copy is the hide value.
- R2: A write selects its target with wr_addr[6:5]. 2'b00 is the position, and wr_addr[4:0] is ignored. 2'b01 is mask row wr_addr[4:0]. 2'b10 is image row wr_addr[4:0]. 2'b11 is discarded and changes nothing.
- R3: The position word holds X in bits 31:16 and Y in bits 15:0, both 16-bit two's complement. The cursor covers pixels X..X+31 horizontally and Y..Y+31 vertically, and row r of the planes maps to pixel line Y+r.
- R4: When both halves of the active position equal 16'h8000, no pixel is ever reported as a cursor pixel.
- R5: A pixel is a cursor pixel only when its mask bit is 1. cursor_fg equals the image bit for a cursor pixel and is 0 otherwise, so an image bit under a 0 mask bit has no effect.
- R6: Within a row word, bit 31 is the leftmost cursor column (offset 0) and bit 0 is the rightmost (offset 31).
- R7: Writes change only the shadow copy. The active copy changes only on a clock edge where frame_start is 1, and then takes the shadow value held before that edge. A write in the same cycle as frame_start therefore waits for the following frame start.
- R8: cursor_on and cursor_fg for a coordinate appear at the first clock edge after the coordinate is presented, and hold until the next edge.
- R9: With a negative X or Y, only the part of the cursor at non-negative pixel coordinates is shown, and each shown pixel uses the offset it has from the true position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 7 | Write target: select in bits 6:5, row in bits 4:0 |
| wr_data | input | 32 | Write data (position word or row word) |
| frame_start | input | 1 | Pulse that copies the shadow copy to the active copy |
| pix_x | input | 16 | Current scan-out pixel column (unsigned) |
| pix_y | input | 16 | Current scan-out pixel line (unsigned) |
| cursor_on | output | 1 | Registered: previous coordinate is a cursor pixel |
| cursor_fg | output | 1 | Registered: that cursor pixel uses the foreground colour |

## Verification
The hardest case to reach is the exchange between the shadow and active copies: a write in the same cycle as frame_start, and a write with no frame start after it. In both cases the write must stay invisible at the pixel outputs. Directed sequences set up each case with a probe pattern chosen so that the old and new contents give different answers. Clipping at a negative position is reached by placing the cursor a few pixels above and left of the origin. Random rounds load full random bitmaps and positions around the origin, then scan random pixels inside and just outside the cursor box.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // Target selected by the two top address bits of a write.
    typedef enum logic [1:0] {
        SEL_POS   = 2'b00,
        SEL_MASK  = 2'b01,
        SEL_IMAGE = 2'b10,
        SEL_NONE  = 2'b11
    } wr_sel_e;

    // Registered per-pixel result.
    typedef struct packed {
        logic on;
        logic fg;
    } pix_out_t;

endpackage

// File: rtl/cursor_planes.sv
module cursor_planes
    import cursor_pkg::*;
#(
    parameter int          COORD_W = 16,
    parameter int          CUR_H   = 32,
    parameter logic [15:0] HIDE    = 16'h8000,
    localparam int DATA_W = 2 * COORD_W,
    localparam int CUR_W  = DATA_W,
    localparam int ROW_W  = $clog2(CUR_H),
    localparam int ADDR_W = ROW_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       frame_start,
    input  logic [ROW_W-1:0]           rd_row,
    output logic [CUR_W-1:0]           act_mask_row,
    output logic [CUR_W-1:0]           act_img_row,
    output logic signed [COORD_W-1:0]  act_x,
    output logic signed [COORD_W-1:0]  act_y,
    output logic                       act_hidden
);

    typedef struct {
        logic [CUR_W-1:0]  shd_mask [CUR_H];
        logic [CUR_W-1:0]  shd_img  [CUR_H];
        logic [CUR_W-1:0]  act_mask [CUR_H];
        logic [CUR_W-1:0]  act_img  [CUR_H];
        logic [DATA_W-1:0] shd_pos;
        logic [DATA_W-1:0] act_pos;
    } plane_state_t;

    localparam logic [DATA_W-1:0] HIDE_POS = {HIDE[COORD_W-1:0], HIDE[COORD_W-1:0]};

    plane_state_t st_d, st_q;
    wr_sel_e      sel;
    logic [ROW_W-1:0] wr_row;

    assign sel    = wr_sel_e'(wr_addr[ADDR_W-1 -: 2]);
    assign wr_row = wr_addr[ROW_W-1:0];

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.act_mask = st_q.shd_mask;
            st_d.act_img  = st_q.shd_img;
            st_d.act_pos  = st_q.shd_pos;
        end
        if (wr_en) begin
            case (sel)
                SEL_POS:   st_d.shd_pos = wr_data;
                SEL_MASK:  if (int'(wr_row) < CUR_H) st_d.shd_mask[wr_row] = wr_data;
                SEL_IMAGE: if (int'(wr_row) < CUR_H) st_d.shd_img[wr_row]  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CUR_H; i++) begin
                st_q.shd_mask[i] <= '0;
                st_q.shd_img[i]  <= '0;
                st_q.act_mask[i] <= '0;
                st_q.act_img[i]  <= '0;
            end
            st_q.shd_pos <= HIDE_POS;
            st_q.act_pos <= HIDE_POS;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_mask_row = st_q.act_mask[rd_row];
    assign act_img_row  = st_q.act_img[rd_row];
    assign act_x        = st_q.act_pos[DATA_W-1:COORD_W];
    assign act_y        = st_q.act_pos[COORD_W-1:0];
    assign act_hidden   = (st_q.act_pos == HIDE_POS);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.act_pos)); // R7

    AST_COPY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> st_q.act_pos == $past(st_q.shd_pos)); // R7

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
    parameter int COORD_W = 16,
    parameter int CUR_W   = 32,
    parameter int CUR_H   = 32,
    localparam int ROW_W  = $clog2(CUR_H),
    localparam int COL_W  = $clog2(CUR_W),
    localparam int DIFF_W = COORD_W + 2
) (
    input  logic [COORD_W-1:0]         pix_x,
    input  logic [COORD_W-1:0]         pix_y,
    input  logic signed [COORD_W-1:0]  pos_x,
    input  logic signed [COORD_W-1:0]  pos_y,
    input  logic                       hidden,
    output logic                       hit,
    output logic [ROW_W-1:0]           row,
    output logic [COL_W-1:0]           col
);

    logic signed [DIFF_W-1:0] dx, dy;
    logic                     in_x, in_y;

    // Offsets of the scan pixel from the cursor origin, wide enough for
    // an unsigned pixel minus a signed position.
    assign dx = $signed({2'b00, pix_x}) - $signed({{2{pos_x[COORD_W-1]}}, pos_x});
    assign dy = $signed({2'b00, pix_y}) - $signed({{2{pos_y[COORD_W-1]}}, pos_y});

    assign in_x = (dx >= 0) && (dx < $signed(DIFF_W'(CUR_W)));
    assign in_y = (dy >= 0) && (dy < $signed(DIFF_W'(CUR_H)));

    assign hit = !hidden && in_x && in_y;
    assign row = dy[ROW_W-1:0];
    // Leftmost cursor column sits in the most significant bit.
    assign col = COL_W'(CUR_W - 1) - dx[COL_W-1:0];

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int          COORD_W = 16,
    parameter int          CUR_H   = 32,
    parameter logic [15:0] HIDE    = 16'h8000,
    localparam int DATA_W = 2 * COORD_W,
    localparam int CUR_W  = DATA_W,
    localparam int ROW_W  = $clog2(CUR_H),
    localparam int COL_W  = $clog2(CUR_W),
    localparam int ADDR_W = ROW_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    output logic              cursor_on,
    output logic              cursor_fg
);

    logic [CUR_W-1:0]          mask_row, img_row;
    logic signed [COORD_W-1:0] act_x, act_y;
    logic                      act_hidden;
    logic                      hit;
    logic [ROW_W-1:0]          row;
    logic [COL_W-1:0]          col;
    pix_out_t                  out_d, out_q;

    cursor_planes #(
        .COORD_W (COORD_W),
        .CUR_H   (CUR_H),
        .HIDE    (HIDE)
    ) u_planes (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .frame_start  (frame_start),
        .rd_row       (row),
        .act_mask_row (mask_row),
        .act_img_row  (img_row),
        .act_x        (act_x),
        .act_y        (act_y),
        .act_hidden   (act_hidden)
    );

    cursor_hit #(
        .COORD_W (COORD_W),
        .CUR_W   (CUR_W),
        .CUR_H   (CUR_H)
    ) u_hit (
        .pix_x  (pix_x),
        .pix_y  (pix_y),
        .pos_x  (act_x),
        .pos_y  (act_y),
        .hidden (act_hidden),
        .hit    (hit),
        .row    (row),
        .col    (col)
    );

    always_comb begin
        out_d.on = hit && mask_row[col];
        out_d.fg = out_d.on && img_row[col];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cursor_on = out_q.on;
    assign cursor_fg = out_q.fg;

    AST_HIDDEN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        act_hidden |=> !cursor_on); // R4

    AST_FG_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_fg |-> cursor_on); // R5

    AST_MISS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !cursor_on); // R9

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> !cursor_on && !cursor_fg); // R1

endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [6:0]  wr_addr;
    logic [31:0] wr_data;
    logic        frame_start;
    logic [15:0] pix_x, pix_y;
    logic        cursor_on, cursor_fg;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of shadow and active copies.
    logic [31:0] m_smask [32];
    logic [31:0] m_simg  [32];
    logic [31:0] m_amask [32];
    logic [31:0] m_aimg  [32];
    logic [31:0] m_spos, m_apos;

    always #2 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .cursor_on   (cursor_on),
        .cursor_fg   (cursor_fg)
    );

    function automatic logic [1:0] expect_px(int x, int y);
        int px, py, dx, dy;
        logic m, im;
        px = int'($signed(m_apos[31:16]));
        py = int'($signed(m_apos[15:0]));
        if (m_apos == 32'h8000_8000) return 2'b00;
        dx = x - px;
        dy = y - py;
        if (dx < 0 || dx > 31 || dy < 0 || dy > 31) return 2'b00;
        m  = m_amask[dy][31-dx];
        im = m_aimg[dy][31-dx];
        return {m, m & im};
    endfunction

    task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got on/fg=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic model_write(logic [6:0] a, logic [31:0] d);
        case (a[6:5])
            2'b00: m_spos = d;
            2'b01: m_smask[a[4:0]] = d;
            2'b10: m_simg[a[4:0]] = d;
            default: ;
        endcase
    endtask

    task automatic model_frame();
        m_amask = m_smask;
        m_aimg  = m_simg;
        m_apos  = m_spos;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        model_frame();
    endtask

    // Write and frame start in the same cycle: the copy sees the old shadow.
    task automatic wr_with_frame(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; frame_start = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0;
        model_frame();
        model_write(a, d);
    endtask

    function automatic logic [31:0] pos(int x, int y);
        return {x[15:0], y[15:0]};
    endfunction

    task automatic probe(string tag, int x, int y);
        @(negedge clk);
        pix_x = x[15:0]; pix_y = y[15:0];
        @(negedge clk);
        check(tag, {cursor_on, cursor_fg}, expect_px(x, y));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        frame_start = 1'b0; pix_x = '0; pix_y = '0;
        for (int i = 0; i < 32; i++) begin
            m_smask[i] = '0; m_simg[i] = '0; m_amask[i] = '0; m_aimg[i] = '0;
        end
        m_spos = 32'h8000_8000; m_apos = 32'h8000_8000;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {cursor_on, cursor_fg}, 2'b00);
        rst_n = 1'b1;
        probe("R1 hidden after reset", 0, 0);
        // Planes cleared: visible position, but nothing drawn.
        wr(7'h00, pos(0, 0));
        frame();
        probe("R1 planes cleared", 0, 0);
        probe("R1 planes cleared", 31, 31);

        // Basic placement and shadow isolation.
        wr(7'h00, pos(10, 20));
        wr(7'h20, 32'h8000_0000);
        wr(7'h40, 32'h8000_0000);
        probe("R7 shadow not yet active", 10, 20);
        check("R7 shadow not yet active direct", {cursor_on, cursor_fg}, 2'b00);
        frame();
        probe("R3 origin pixel", 10, 20);
        check("R3 origin pixel direct", {cursor_on, cursor_fg}, 2'b11);
        probe("R6 second column", 11, 20);

        // Full row, image only in the low half.
        wr(7'h21, 32'hFFFF_FFFF);
        wr(7'h41, 32'h0000_FFFF);
        frame();
        probe("R6 left column bg", 10, 21);
        check("R5 background colour", {cursor_on, cursor_fg}, 2'b10);
        probe("R6 right column fg", 41, 21);
        check("R6 right column direct", {cursor_on, cursor_fg}, 2'b11);
        probe("R3 past right edge", 42, 21);
        probe("R3 before left edge", 9, 21);
        probe("R3 below last row", 10, 52);

        // Latency: output holds until the next edge.
        @(negedge clk); pix_x = 16'd10; pix_y = 16'd20;
        @(negedge clk); pix_x = 16'd200; pix_y = 16'd200;
        #1 check("R8 holds before next edge", {cursor_on, cursor_fg}, 2'b11);
        @(negedge clk);
        check("R8 updates after one edge", {cursor_on, cursor_fg}, 2'b00);

        // Image bit without mask bit.
        wr(7'h42, 32'hFFFF_FFFF);
        frame();
        probe("R5 image without mask", 15, 22);
        check("R5 image without mask direct", {cursor_on, cursor_fg}, 2'b00);

        // Discarded select and aliased position address.
        wr(7'h60, 32'h0000_0000);
        wr(7'h7F, 32'h0000_0000);
        frame();
        probe("R2 discarded select", 10, 20);
        wr(7'h1F, pos(12, 20));
        frame();
        probe("R2 position alias", 12, 20);
        check("R2 position alias direct", {cursor_on, cursor_fg}, 2'b11);

        // Hide coordinate.
        wr(7'h00, 32'h8000_8000);
        frame();
        probe("R4 hidden", 12, 20);
        probe("R4 hidden", 13, 21);

        // Negative position clipping.
        wr(7'h23, 32'h0400_0000);
        wr(7'h43, 32'h0400_0000);
        wr(7'h00, pos(-5, -3));
        frame();
        probe("R9 clipped pixel", 0, 0);
        check("R9 clipped pixel direct", {cursor_on, cursor_fg}, 2'b11);
        probe("R9 clipped row", 0, 1);

        // Write in the frame-start cycle waits a frame.
        wr_with_frame(7'h00, pos(100, 100));
        probe("R7 same-cycle write deferred", 0, 0);
        check("R7 same-cycle write deferred direct", {cursor_on, cursor_fg}, 2'b11);
        frame();
        probe("R7 applied next frame", 100, 100);

        // Random rounds.
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < 32; i++) begin
                wr(7'h20 | 7'(i), $urandom);
                wr(7'h40 | 7'(i), $urandom);
            end
            wr(7'h00, pos(int'($urandom_range(140)) - 40, int'($urandom_range(140)) - 40));
            frame();
            for (int k = 0; k < 40; k++) begin
                probe("R5 random scan", int'($urandom_range(140)), int'($urandom_range(140)));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule